// File: doc/BRIEF.md
# Rotating-Boundary Collapsing Issue Queue

This block is an age-ordered issue queue. It keeps its occupied slots as one contiguous run inside a circular array of physical slots. A head pointer marks the oldest slot, and the occupancy count gives the tail. New entries always join at the tail.

When an entry issues, the hole it leaves is closed by moving entries by one slot. Which side moves depends on a rotating boundary pointer:

- If the issued entry lies between the head and the boundary, the entries older than it step one slot toward the tail, and the head advances.
- Otherwise, the entries younger than it step one slot toward the head.

The boundary moves forward by one slot after every fixed number of accepted issues. Because of this, and because the head drifts when older entries move, write activity is spread over all physical slots instead of piling up near a fixed head.

A per-slot clock-enable vector decides which slots load in a cycle. Every slot that does not load keeps its contents. The outputs are:

- an oldest-first view of the stored tags, with a valid mask;
- full and empty flags;
- the head and boundary pointers, so a user can name a physical slot for issue;
- one write counter per physical slot, so wear balance can be observed.

DEPTH must be a power of two and at least 2.

Top module: `iq_rr_top`

## Requirements
- R1: After reset the queue is empty: empty=1, full=0, headPtr=0, phPtr=0, every valid bit 0, every view field 0, and every swap counter 0.
- R2: An allocation accepted while not full appends the tag as the youngest entry. ordView field k (bits k*TAG_W upward) holds the k-th oldest tag, ordValid bit k is set for each occupied position, and unoccupied fields read 0.
- R3: full is 1 exactly when DEPTH entries are held. An allocation while full is refused, even if an issue is accepted in the same cycle, and it leaves the view unchanged.
- R4: An issue naming physical slot s, with logical offset k=(s-headPtr) mod DEPTH below the occupancy, where k is less than the boundary offset (phPtr-headPtr) mod DEPTH, removes that entry. The k older entries each move one slot toward the tail, and headPtr advances by one. The relative age order of the remaining entries is kept.
- R5: An accepted issue that does not meet the R4 condition removes the entry and moves each younger entry one slot toward the head. headPtr is unchanged and age order is kept.
- R6: In each cycle only the shift destinations and the allocation target load new data. The swap counter of a physical slot (bits s*CNT_W upward) rises by exactly one in each cycle that slot loads, and is unchanged otherwise.
- R7: phPtr advances by one, modulo DEPTH, on every ISSUE_PER_STEP-th accepted issue.
- R8: An issue naming a slot whose offset is not below the occupancy, including any issue while empty, is ignored. It changes nothing and does not count toward R7.
- R9: When an allocation and an issue are both accepted in one cycle, the collapse of R4 or R5 is applied first, the new tag becomes the youngest entry, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Request to append a new entry |
| allocTag | input | TAG_W | Tag payload of the new entry |
| issueReq | input | 1 | Request to remove an entry |
| issueSlot | input | log2(DEPTH) | Physical slot of the entry to remove |
| ordView | output | DEPTH*TAG_W | Tags in oldest-first order |
| ordValid | output | DEPTH | Valid mask of ordView positions |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| headPtr | output | log2(DEPTH) | Physical slot of the oldest entry |
| phPtr | output | log2(DEPTH) | Rotating collapse boundary slot |
| swapCnt | output | DEPTH*CNT_W | Per-slot load counters |

## Verification
The bench builds the queue with DEPTH=8, TAG_W=8, CNT_W=16 and ISSUE_PER_STEP=2. With a two-issue step, the boundary moves within a few operations, so both collapse directions can be reached from a freshly filled queue in a handful of cycles. Eight slots let the head and boundary wrap several times during a 400-cycle pseudo-random phase. That phase also drives every slot's counter off zero and exercises full/issue and empty/issue collisions often.

// File: rtl/iq_rr_pkg.sv
package iq_rr_pkg;

  // Cycle strobes passed from control to datapath.
  typedef struct packed {
    logic doAlloc;    // allocation target slot loads the new tag
    logic shiftPrev;  // enabled slots take the content of the slot before them
    logic shiftNext;  // enabled slots take the content of the slot after them
  } iqStrobe_t;

endpackage

// File: rtl/iq_rr_ctrl.sv
module iq_rr_ctrl
  import iq_rr_pkg::*;
#(
  parameter int DEPTH          = 16,
  parameter int ISSUE_PER_STEP = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocReq,
  input  logic             issueReq,
  input  logic [PTR_W-1:0] issueSlot,
  output iqStrobe_t        strobe,
  output logic [DEPTH-1:0] clkEn,
  output logic [PTR_W-1:0] allocSlot,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] phPtr,
  output logic [OCC_W-1:0] occCount,
  output logic             full,
  output logic             empty
);

  localparam int IC_W = (ISSUE_PER_STEP > 1) ? $clog2(ISSUE_PER_STEP) : 1;
  localparam logic [IC_W-1:0] IC_LAST = IC_W'(ISSUE_PER_STEP - 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

  logic [PTR_W-1:0] headQ;
  logic [PTR_W-1:0] phQ;
  logic [OCC_W-1:0] occQ;
  logic [IC_W-1:0]  icQ;

  logic [PTR_W-1:0] issOff;
  logic [PTR_W-1:0] phOff;
  logic [OCC_W-1:0] allocOff;
  logic             issueOk;
  logic             allocOk;
  logic             olderSide;

  assign issOff    = issueSlot - headQ;
  assign phOff     = phQ - headQ;
  assign issueOk   = issueReq && (OCC_W'(issOff) < occQ);
  assign allocOk   = allocReq && (occQ != OCC_FULL);
  assign olderSide = issueOk && (issOff < phOff);

  // Slot that receives a new tag, after the collapse of this cycle
  assign allocOff  = (issueOk && !olderSide) ? (occQ - OCC_W'(1)) : occQ;
  assign allocSlot = headQ + PTR_W'(allocOff);

  assign strobe.doAlloc   = allocOk;
  assign strobe.shiftPrev = olderSide;
  assign strobe.shiftNext = issueOk && !olderSide;

  // Per-slot clock-enable (collapse control) vector
  for (genvar s = 0; s < DEPTH; s++) begin : g_en
    logic [PTR_W-1:0] slotOff;
    logic             isAllocTgt;
    logic             inOlderRun;
    logic             inYoungerRun;

    assign slotOff      = PTR_W'(s) - headQ;
    assign isAllocTgt   = allocOk && (PTR_W'(s) == allocSlot);
    assign inOlderRun   = olderSide && (slotOff != '0) && (slotOff <= issOff);
    assign inYoungerRun = strobe.shiftNext && (slotOff >= issOff) &&
                          ((OCC_W'(slotOff) + OCC_W'(1)) < occQ);
    assign clkEn[s]     = isAllocTgt || inOlderRun || inYoungerRun;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      phQ   <= '0;
      occQ  <= '0;
      icQ   <= '0;
    end else begin
      if (olderSide) begin
        headQ <= headQ + PTR_W'(1);
      end
      occQ <= occQ + OCC_W'(allocOk) - OCC_W'(issueOk);
      if (issueOk) begin
        if (icQ == IC_LAST) begin
          icQ <= '0;
          phQ <= phQ + PTR_W'(1);
        end else begin
          icQ <= icQ + IC_W'(1);
        end
      end
    end
  end

  assign headPtr  = headQ;
  assign phPtr    = phQ;
  assign occCount = occQ;
  assign full     = (occQ == OCC_FULL);
  assign empty    = (occQ == '0);

endmodule

// File: rtl/iq_rr_data.sv
module iq_rr_data
  import iq_rr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  iqStrobe_t                    strobe,
  input  logic [DEPTH-1:0]             clkEn,
  input  logic [PTR_W-1:0]             allocSlot,
  input  logic [TAG_W-1:0]             allocTag,
  output logic [DEPTH-1:0][TAG_W-1:0]  slotTag,
  output logic [DEPTH-1:0][CNT_W-1:0]  slotCnt
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    localparam int PREV = (s + DEPTH - 1) % DEPTH;
    localparam int NEXT = (s + 1) % DEPTH;

    logic [TAG_W-1:0] tagR;
    logic [CNT_W-1:0] cntR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagR <= '0;
        cntR <= '0;
      end else if (clkEn[s]) begin
        cntR <= cntR + CNT_W'(1);
        if (strobe.doAlloc && (allocSlot == PTR_W'(s))) begin
          tagR <= allocTag;
        end else if (strobe.shiftPrev) begin
          tagR <= slotTag[PREV];
        end else if (strobe.shiftNext) begin
          tagR <= slotTag[NEXT];
        end
      end
    end

    assign slotTag[s] = tagR;
    assign slotCnt[s] = cntR;
  end

endmodule

// File: rtl/iq_rr_top.sv
module iq_rr_top
  import iq_rr_pkg::*;
#(
  parameter int DEPTH          = 16,
  parameter int TAG_W          = 8,
  parameter int CNT_W          = 16,
  parameter int ISSUE_PER_STEP = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     allocReq,
  input  logic [TAG_W-1:0]         allocTag,
  input  logic                     issueReq,
  input  logic [PTR_W-1:0]         issueSlot,
  output logic [DEPTH*TAG_W-1:0]   ordView,
  output logic [DEPTH-1:0]         ordValid,
  output logic                     full,
  output logic                     empty,
  output logic [PTR_W-1:0]         headPtr,
  output logic [PTR_W-1:0]         phPtr,
  output logic [DEPTH*CNT_W-1:0]   swapCnt
);

  iqStrobe_t                   strobe;
  logic [DEPTH-1:0]            clkEn;
  logic [PTR_W-1:0]            allocSlot;
  logic [OCC_W-1:0]            occCount;
  logic [DEPTH-1:0][TAG_W-1:0] slotTag;
  logic [DEPTH-1:0][CNT_W-1:0] slotCnt;

  iq_rr_ctrl #(
    .DEPTH(DEPTH),
    .ISSUE_PER_STEP(ISSUE_PER_STEP)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .allocReq(allocReq),
    .issueReq(issueReq),
    .issueSlot(issueSlot),
    .strobe(strobe),
    .clkEn(clkEn),
    .allocSlot(allocSlot),
    .headPtr(headPtr),
    .phPtr(phPtr),
    .occCount(occCount),
    .full(full),
    .empty(empty)
  );

  iq_rr_data #(
    .DEPTH(DEPTH),
    .TAG_W(TAG_W),
    .CNT_W(CNT_W)
  ) data_i (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .clkEn(clkEn),
    .allocSlot(allocSlot),
    .allocTag(allocTag),
    .slotTag(slotTag),
    .slotCnt(slotCnt)
  );

  // Oldest-first view, rotated from the head pointer
  for (genvar k = 0; k < DEPTH; k++) begin : g_view
    logic [PTR_W-1:0] physIdx;
    logic             live;
    assign physIdx = headPtr + PTR_W'(k);
    assign live    = OCC_W'(k) < occCount;
    assign ordValid[k] = live;
    assign ordView[k*TAG_W +: TAG_W] = live ? slotTag[physIdx] : '0;
  end

  assign swapCnt = slotCnt;

endmodule

// File: rtl/iq_rr_chk.sv
module iq_rr_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   allocReq,
  input logic                   issueReq,
  input logic                   full,
  input logic                   empty,
  input logic [PTR_W-1:0]       headPtr,
  input logic [PTR_W-1:0]       phPtr,
  input logic [OCC_W-1:0]       occCount,
  input logic [DEPTH*CNT_W-1:0] swapCnt
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && allocReq && !issueReq) |=> (full && $stable(occCount)));

  p_alloc_append_r2: assert property (@(posedge clk) disable iff (!rstN)
    (allocReq && !full && !issueReq) |=> (!empty && occCount == $past(occCount) + OCC_W'(1)));

  p_head_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (headPtr == $past(headPtr)) || (headPtr == PTR_W'($past(headPtr) + PTR_W'(1))));

  p_ph_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phPtr == $past(phPtr)) || (phPtr == PTR_W'($past(phPtr) + PTR_W'(1))));

  p_empty_issue_r8: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !allocReq) |=> (empty && $stable(headPtr) && $stable(phPtr)));

  p_both_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (empty && allocReq && issueReq) |=> (occCount == OCC_W'(1)));

  for (genvar s = 0; s < DEPTH; s++) begin : g_cnt
    p_swap_step_r6: assert property (@(posedge clk) disable iff (!rstN)
      (swapCnt[s*CNT_W +: CNT_W] == $past(swapCnt[s*CNT_W +: CNT_W])) ||
      (swapCnt[s*CNT_W +: CNT_W] == CNT_W'($past(swapCnt[s*CNT_W +: CNT_W]) + CNT_W'(1))));
  end

endmodule

bind iq_rr_top iq_rr_chk #(
  .DEPTH(DEPTH),
  .CNT_W(CNT_W)
) chk_i (
  .clk(clk),
  .rstN(rstN),
  .allocReq(allocReq),
  .issueReq(issueReq),
  .full(full),
  .empty(empty),
  .headPtr(headPtr),
  .phPtr(phPtr),
  .occCount(occCount),
  .swapCnt(swapCnt)
);

// File: tb/iq_rr_top_tb_top.sv
module iq_rr_top_tb_top;

  localparam int D  = 8;
  localparam int TW = 8;
  localparam int CW = 16;
  localparam int K  = 2;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          allocReq;
  logic [TW-1:0] allocTag;
  logic          issueReq;
  logic [PW-1:0] issueSlot;
  logic [D*TW-1:0] ordView;
  logic [D-1:0]    ordValid;
  logic            full;
  logic            empty;
  logic [PW-1:0]   headPtr;
  logic [PW-1:0]   phPtr;
  logic [D*CW-1:0] swapCnt;

  always #5 clk = ~clk;

  iq_rr_top #(
    .DEPTH(D), .TAG_W(TW), .CNT_W(CW), .ISSUE_PER_STEP(K)
  ) dut_i (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocTag(allocTag),
    .issueReq(issueReq), .issueSlot(issueSlot), .ordView(ordView),
    .ordValid(ordValid), .full(full), .empty(empty), .headPtr(headPtr),
    .phPtr(phPtr), .swapCnt(swapCnt)
  );

  int total = 0;
  int bad   = 0;

  // Reference state: logical list plus pointer and wear bookkeeping
  int mList[D];
  int mLen;
  int mHead;
  int mPh;
  int mIc;
  int mSwap[D];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    logic [D*TW-1:0] ev;
    logic [D-1:0]    evld;
    ev   = '0;
    evld = '0;
    for (int k = 0; k < mLen; k++) begin
      ev[k*TW +: TW] = TW'(mList[k]);
      evld[k] = 1'b1;
    end
    chk(req, "view",  64'(ordView), 64'(ev));
    chk(req, "valid", 64'(ordValid), 64'(evld));
    chk(req, "full",  64'(full), 64'(mLen == D));
    chk(req, "empty", 64'(empty), 64'(mLen == 0));
    chk(req, "head",  64'(headPtr), 64'(mHead));
    chk(req, "ph",    64'(phPtr), 64'(mPh));
    for (int s = 0; s < D; s++)
      chk(req, $sformatf("swap[%0d]", s), 64'(swapCnt[s*CW +: CW]), 64'(mSwap[s]));
  endtask

  task automatic modelStep(input logic a, input logic [TW-1:0] tg, input logic i, input int slot);
    int  kk;
    int  q;
    bit  iv;
    bit  older;
    bit  av;
    kk    = (slot - mHead + D) % D;
    q     = (mPh - mHead + D) % D;
    iv    = i && (kk < mLen);
    older = iv && (kk < q);
    av    = a && (mLen < D);
    if (iv) begin
      if (older) begin
        for (int o = 1; o <= kk; o++) mSwap[(mHead + o) % D]++;
      end else begin
        for (int o = kk; o <= mLen - 2; o++) mSwap[(mHead + o) % D]++;
      end
      for (int o = kk; o < mLen - 1; o++) mList[o] = mList[o + 1];
      mLen--;
      if (older) mHead = (mHead + 1) % D;
      mIc++;
      if (mIc == K) begin
        mIc = 0;
        mPh = (mPh + 1) % D;
      end
    end
    if (av) begin
      mSwap[(mHead + mLen) % D]++;
      mList[mLen] = int'(tg);
      mLen++;
    end
  endtask

  // One operation; k is a logical offset from the current head
  task automatic cyc(input logic a, input logic [TW-1:0] tg, input logic i,
                     input int k, input string req);
    int slot;
    slot      = (mHead + k) % D;
    allocReq  = a;
    allocTag  = tg;
    issueReq  = i;
    issueSlot = PW'(slot);
    @(posedge clk);
    modelStep(a, tg, i, slot);
    @(negedge clk);
    allocReq = 1'b0;
    issueReq = 1'b0;
    checkAll(req);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    allocReq = 1'b0; allocTag = '0; issueReq = 1'b0; issueSlot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mLen = 0; mHead = 0; mPh = 0; mIc = 0;
    for (int s = 0; s < D; s++) begin mSwap[s] = 0; mList[s] = 0; end
    checkAll("R1");
  endtask

  task automatic tFill();
    for (int n = 0; n < D; n++) cyc(1'b1, TW'(8'h10 + n), 1'b0, 0, "R2");
    cyc(1'b1, 8'hEE, 1'b0, 0, "R3");
  endtask

  task automatic tCollapse();
    cyc(1'b0, '0, 1'b1, 3, "R5");   // boundary at head: younger side moves
    cyc(1'b0, '0, 1'b1, 0, "R7");   // second issue steps the boundary
    cyc(1'b0, '0, 1'b1, 0, "R4");   // below boundary: older side, head moves
    cyc(1'b0, '0, 1'b1, 2, "R5");
    cyc(1'b0, '0, 1'b1, 0, "R4");
  endtask

  task automatic tIgnore();
    cyc(1'b0, '0, 1'b1, mLen, "R8");
    cyc(1'b0, '0, 1'b1, D - 1, "R8");
  endtask

  task automatic tBoth();
    cyc(1'b1, 8'hA0, 1'b1, 1, "R9");
    cyc(1'b1, 8'hA1, 1'b1, 0, "R9");
    while (mLen < D) cyc(1'b1, TW'(8'hB0 + mLen), 1'b0, 0, "R2");
    cyc(1'b1, 8'hCC, 1'b1, 2, "R3");  // full: alloc refused, issue taken
  endtask

  task automatic tDrain();
    while (mLen > 0) cyc(1'b0, '0, 1'b1, mLen / 2, "R5");
    cyc(1'b0, '0, 1'b1, 0, "R8");
    cyc(1'b1, 8'h55, 1'b1, 0, "R9");  // empty: issue ignored, alloc taken
  endtask

  task automatic tSoak();
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[5], TW'(lfsr[15:8]), lfsr[1] | lfsr[7],
          int'(lfsr[4:2]), "R6");
    end
    for (int s = 0; s < D; s++)
      chk("R6", $sformatf("slot %0d used", s), 64'(swapCnt[s*CW +: CW] != '0), 64'd1);
  endtask

  initial begin
    tReset();
    tFill();
    tCollapse();
    tIgnore();
    tBoth();
    tDrain();
    tSoak();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule